// File: doc/BRIEF.md
# Infrared Run-Length Transmitter with Carrier

This block turns a stream of run-length samples into an infrared drive level. Each sample is one byte. Its top bit says whether the interval is a mark (pulse) or a gap (space), and its lower seven bits give the interval length in sample units. During a mark the output either holds a steady active level or toggles with a carrier. The carrier's period and high time are both programmed in 500 ns steps. An output inversion bit serves emitters that are driven active-low.

Software writes samples into two holding slots, A and B, through a simple register write port. Once started, the block plays slot A, then slot B, then A again, and so on. It empties each slot when it takes the sample from it. When a sample ends and the other slot holds a new sample, the interrupt line pulses so that software can refill the slot just played. A zero-length sample, or an empty slot, ends the run and returns the output to its idle level. The end of a run can also raise the interrupt.

Top module: `irtx_top`

## Requirements
- R1: After reset, `ir_o` is 0 and `irq_o` is 0.
- R2: Register addresses are: 0 = control, 1 = slot A, 2 = slot B, 3 = carrier period, 4 = carrier high time. The control bits are: bit 0 run, bit 1 modulate marks with the carrier, bit 2 invert the output, bit 3 interrupt on end of run. The period register holds the carrier polarity in bit 7 and the period in bits 6:0. The high time sits in bits 6:0. Slot byte: bit 7 = 1 means mark, bits 6:0 give the length.
- R3: A control write with bit 0 set, while the block is idle, loads slot A on that clock edge. Each sample then drives the output for exactly length × UNIT_CYC clocks. The next sample follows with no gap, taken from the other slot.
- R4: Without modulation, a mark drives level 1 and a space drives level 0 (both before inversion).
- R5: With modulation, a mark drives ((floor(t / HALF_CYC) mod P) < H) XOR polarity. Here t counts clocks from the start of the sample, P is the effective period and H is the high time. The carrier phase restarts at every sample.
- R6: A programmed period of 0 or 1 acts as a period of 2.
- R7: A slot is emptied when its sample is taken. A run in which the next slot has length 0 ends on that edge, and the output goes to the idle level. Starting with an empty slot A ends the run at once.
- R8: When a sample ends and the other slot holds a non-zero length, `irq_o` is 1 for exactly the following clock.
- R9: When a run ends, `irq_o` pulses for one clock only if control bit 3 is set. No refill pulse comes from the final sample.
- R10: A control write with bit 0 clear stops a run on that edge, with no interrupt. The output shows the idle level from the next clock.
- R11: The inversion bit applies to every output level, including idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| ir_o | output | 1 | Infrared drive level |
| irq_o | output | 1 | One-clock interrupt pulse |

## Verification
The bench builds the block with HALF_CYC = 2 and UNIT_CYC = 3. With these values one 500 ns carrier step lasts two clocks and one length unit lasts three. A twelve-unit mark therefore covers a whole carrier period of every value swept, so each clock of the mark can be predicted. The sweep covers period codes 0 to 9 (including the clamped ones), every high time from 0 up to past the period, both carrier polarities and both output senses. Short directed runs cover alternating slots, refill during play, self-termination on an emptied slot, the gating of the end-of-run interrupt, and abort.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SLOT0 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CPER  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CHIGH = 3'd4;

  typedef struct packed {
    logic [3:0] spare;
    logic       fin_irq;
    logic       invert;
    logic       modulate;
    logic       run;
  } ctrl_t;

  // Carrier period with the lower bound applied.
  function automatic logic [LEN_W-1:0] eff_period(input logic [LEN_W-1:0] raw);
    return (raw < LEN_W'(2)) ? LEN_W'(2) : raw;
  endfunction

  // Next carrier phase, wrapping at the effective period.
  function automatic logic [LEN_W-1:0] phase_next(input logic [LEN_W-1:0] ph,
                                                 input logic [LEN_W-1:0] per);
    return (ph >= per - LEN_W'(1)) ? '0 : ph + LEN_W'(1);
  endfunction

  // Carrier level for a phase.
  function automatic logic carrier_bit(input logic [LEN_W-1:0] ph,
                                       input logic [LEN_W-1:0] high,
                                       input logic pol);
    return (ph < high) ^ pol;
  endfunction
endpackage

// File: rtl/irtx_regs.sv
module irtx_regs
  import irtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output ctrl_t             ctrl_q,
  output logic [LEN_W-1:0]  per_raw,
  output logic              car_pol,
  output logic [LEN_W-1:0]  high_q,
  output logic              start_req,
  output logic              stop_req,
  output logic              fin_en_now
);
  logic ctrl_wr;
  assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
  assign start_req  = ctrl_wr && wr_data[0];
  assign stop_req   = ctrl_wr && !wr_data[0];
  assign fin_en_now = ctrl_wr ? wr_data[3] : ctrl_q.fin_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      per_raw <= LEN_W'(2);
      car_pol <= 1'b0;
      high_q  <= LEN_W'(1);
    end else if (wr_en) begin
      if (wr_addr == A_CTRL)  ctrl_q <= ctrl_t'(wr_data);
      if (wr_addr == A_CPER) begin
        per_raw <= wr_data[LEN_W-1:0];
        car_pol <= wr_data[7];
      end
      if (wr_addr == A_CHIGH) high_q <= wr_data[LEN_W-1:0];
    end
  end
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
  import irtx_pkg::*;
#(
  parameter int UNIT_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start_req,
  input  logic              stop_req,
  output logic              active,
  output logic              cur_pulse,
  output logic              refill_ev,
  output logic              finish_ev,
  output logic              restart
);
  localparam int CYC_W = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam int NSLOT = 2;

  logic [7:0]       slot_q [NSLOT];
  logic             sel;
  logic [LEN_W-1:0] units_left;
  logic [CYC_W-1:0] cyc;

  logic       unit_done, sample_end, load_now, next_idx, nxt_zero;
  logic [7:0] nxt;

  assign unit_done  = active && (cyc == CYC_W'(UNIT_CYC - 1));
  assign sample_end = unit_done && (units_left == LEN_W'(1));
  assign load_now   = (start_req && !active) || sample_end;
  assign next_idx   = active ? ~sel : 1'b0;
  assign nxt        = slot_q[next_idx];
  assign nxt_zero   = (nxt[LEN_W-1:0] == '0);

  assign restart   = load_now && !nxt_zero && !stop_req;
  assign refill_ev = sample_end && !nxt_zero && !stop_req;
  assign finish_ev = load_now && nxt_zero && !stop_req;

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[k] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(int'(A_SLOT0) + k))
        slot_q[k] <= wr_data;
      else if (restart && (int'(next_idx) == k))
        slot_q[k] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sel        <= 1'b0;
      cur_pulse  <= 1'b0;
      units_left <= '0;
      cyc        <= '0;
    end else if (stop_req) begin
      active <= 1'b0;
    end else if (load_now) begin
      if (nxt_zero) begin
        active <= 1'b0;
      end else begin
        active     <= 1'b1;
        sel        <= next_idx;
        cur_pulse  <= nxt[7];
        units_left <= nxt[LEN_W-1:0];
        cyc        <= '0;
      end
    end else if (active) begin
      if (unit_done) begin
        cyc        <= '0;
        units_left <= units_left - LEN_W'(1);
      end else begin
        cyc <= cyc + CYC_W'(1);
      end
    end
  end
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier
  import irtx_pkg::*;
#(
  parameter int HALF_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [LEN_W-1:0] per,
  input  logic [LEN_W-1:0] high,
  input  logic             pol,
  output logic             carrier,
  output logic [LEN_W-1:0] phase
);
  localparam int PRE_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      phase <= '0;
    end else if (!run || restart) begin
      pre   <= '0;
      phase <= '0;
    end else if (pre == PRE_W'(HALF_CYC - 1)) begin
      pre   <= '0;
      phase <= phase_next(phase, per);
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  assign carrier = carrier_bit(phase, high, pol);
endmodule

// File: rtl/irtx_top.sv
module irtx_top
  import irtx_pkg::*;
#(
  parameter int HALF_CYC = 50,
  parameter int UNIT_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              ir_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [LEN_W-1:0] per_raw, eff_per, high_q, car_phase;
  logic             car_pol, start_req, stop_req, fin_en_now;
  logic             seq_active, seq_pulse, refill_ev, finish_ev, restart;
  logic             carrier, inv_w, mark_lvl;

  irtx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .per_raw(per_raw), .car_pol(car_pol), .high_q(high_q),
    .start_req(start_req), .stop_req(stop_req), .fin_en_now(fin_en_now)
  );

  irtx_seq #(.UNIT_CYC(UNIT_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_req(start_req), .stop_req(stop_req), .active(seq_active),
    .cur_pulse(seq_pulse), .refill_ev(refill_ev), .finish_ev(finish_ev),
    .restart(restart)
  );

  assign eff_per = eff_period(per_raw);

  irtx_carrier #(.HALF_CYC(HALF_CYC)) u_car (
    .clk(clk), .rst_n(rst_n), .run(seq_active), .restart(restart),
    .per(eff_per), .high(high_q), .pol(car_pol),
    .carrier(carrier), .phase(car_phase)
  );

  assign inv_w    = ctrl_q.invert;
  assign mark_lvl = ctrl_q.modulate ? carrier : 1'b1;
  assign ir_o     = (seq_active & seq_pulse & mark_lvl) ^ inv_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= refill_ev | (finish_ev & fin_en_now);
  end
endmodule

// File: rtl/irtx_chk.sv
module irtx_chk
  import irtx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             cur_pulse,
  input logic             invert,
  input logic             ir_o,
  input logic             irq_o,
  input logic             refill_ev,
  input logic             finish_ev,
  input logic             stop_req,
  input logic             restart,
  input logic [LEN_W-1:0] phase,
  input logic [LEN_W-1:0] eff_per
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> ir_o == invert); // R11
  AST_SPACE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cur_pulse) |-> ir_o == invert); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(refill_ev || finish_ev)); // R8
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refill_ev, finish_ev})); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !active); // R10
  AST_PHASE_START: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0 && active)); // R5
  AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    eff_per >= LEN_W'(2)); // R6
endmodule

bind irtx_top irtx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(seq_active), .cur_pulse(seq_pulse),
  .invert(inv_w), .ir_o(ir_o), .irq_o(irq_o), .refill_ev(refill_ev),
  .finish_ev(finish_ev), .stop_req(stop_req), .restart(restart),
  .phase(car_phase), .eff_per(eff_per)
);

// File: tb/sim_irtx_top.sv
module sim_irtx_top;
  localparam int HALF = 2;
  localparam int UNIT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ir_o, irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irtx_top #(.HALF_CYC(HALF), .UNIT_CYC(UNIT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ir_o(ir_o), .irq_o(irq_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Write one register; returns at the negedge right after the write edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Check n cycles of a constant level; optional write issued at cycle wr_at.
  task automatic play(input logic lvl, input int n, input logic irq_first,
                      input string tag, input int wr_at,
                      input logic [2:0] wa, input logic [7:0] wd);
    for (int i = 0; i < n; i++) begin
      chk(ir_o, lvl, {tag, " level"});
      chk(irq_o, (i == 0) ? irq_first : 1'b0, {tag, " irq"});
      if (i == wr_at) begin
        wr_en = 1'b1; wr_addr = wa; wr_data = wd;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R3 actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ir_o, 1'b0, "R1 reset ir_o");
    chk(irq_o, 1'b0, "R1 reset irq_o");
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R11 R2: sweep of period code, high time, polarity, inversion
    for (int p = 0; p < 10; p++) begin
      for (int h = 0; h < 11; h++) begin
        for (int pol = 0; pol < 2; pol++) begin
          int pe;
          logic inv;
          pe  = (p < 2) ? 2 : p;
          inv = logic'(h % 2);
          wr(3'd4, 8'(h));
          wr(3'd3, {logic'(pol), 7'(p)});
          wr(3'd1, 8'h80 | 8'd12);
          wr(3'd2, 8'h00);
          wr(3'd0, {4'b0000, 1'b1, inv, 1'b1, 1'b1});
          for (int t = 0; t < 12 * UNIT; t++) begin
            logic e;
            e = ((((t / HALF) % pe) < h) ? 1'b1 : 1'b0) ^ logic'(pol) ^ inv;
            chk(ir_o, e, "R5 R6 carrier sweep");
            chk(irq_o, 1'b0, "R8 no irq mid sample");
            @(negedge clk);
          end
          chk(ir_o, inv, "R7 R11 idle after run");
          chk(irq_o, 1'b1, "R9 end irq enabled");
          @(negedge clk);
          chk(irq_o, 1'b0, "R9 end irq one cycle");
        end
      end
    end

    // R3 R4 R8 R7: alternate slots, plain marks, refill during play
    wr(3'd1, 8'h80 | 8'd4);
    wr(3'd2, 8'h00 | 8'd3);
    wr(3'd0, 8'h09);
    play(1'b1, 4 * UNIT, 1'b0, "R3 R4 slot A mark", -1, 3'd0, 8'h00);
    play(1'b0, 3 * UNIT, 1'b1, "R8 R4 slot B space", 2, 3'd1, 8'h80 | 8'd2);
    play(1'b1, 2 * UNIT, 1'b1, "R3 R8 refilled slot A", -1, 3'd0, 8'h00);
    play(1'b0, 1, 1'b1, "R7 emptied slot B ends run", -1, 3'd0, 8'h00);
    play(1'b0, 2, 1'b0, "R7 idle after end", -1, 3'd0, 8'h00);

    // R7 R9: both slots emptied, start ends at once, end irq disabled
    wr(3'd0, 8'h01);
    play(1'b0, 4, 1'b0, "R7 R9 empty start", -1, 3'd0, 8'h00);

    // R9: normal run without end interrupt
    wr(3'd1, 8'h80 | 8'd2);
    wr(3'd0, 8'h01);
    play(1'b1, 2 * UNIT, 1'b0, "R4 plain mark", -1, 3'd0, 8'h00);
    play(1'b0, 3, 1'b0, "R9 no end irq", -1, 3'd0, 8'h00);

    // R10 R11: abort an inverted run
    wr(3'd1, 8'h80 | 8'd10);
    wr(3'd2, 8'h80 | 8'd5);
    wr(3'd0, 8'h0D);
    play(1'b0, 4, 1'b0, "R11 inverted mark", -1, 3'd0, 8'h00);
    wr(3'd0, 8'h0C);
    play(1'b1, 6, 1'b0, "R10 R11 stopped idle", -1, 3'd0, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule